// File: doc/BRIEF.md
# Page Address Translator with Translation Buffer

This block turns virtual addresses from a processor into physical addresses. It splits each virtual address into a page number and an offset. It looks the page number up in a small, fully associative translation buffer, and every entry of that buffer is compared in parallel. On a hit, the stored frame number is joined with the untouched offset, and the answer is returned one cycle after the request is accepted, with no memory traffic.

On a miss, the block computes where the page's entry sits in a single-level page table held in external memory. It issues one read for that entry and waits for the reply. If the entry's valid bit is set, the block answers with the frame from memory and caches the mapping. If the bit is clear, it answers with a fault and no physical address.

A configuration write loads the table base address. A flush input empties the buffer when the running process changes. Only one translation is in flight at a time.

Top module: `page_xlate`

## Requirements
- R1: After reset the request side is ready, no response and no memory read are active, and the buffer holds no entries, so the first access to any page misses.
- R2: A successful translation returns the frame number in the upper physical address bits above the offset, and the low log2(PAGE_BYTES) offset bits are copied unchanged from the virtual address.
- R3: The page-table entry is read at address base + page_number * PTE_BYTES (modulo 2^PA_W), where base is the value last loaded through `cfg_we`/`cfg_base`.
- R4: A request that hits in the buffer produces `rsp_valid` in the cycle after acceptance, with no fault and no memory read.
- R5: A request that misses makes exactly one memory read, and `rsp_valid` rises in the cycle after the one in which `mem_rsp_valid` is sampled.
- R6: In the read-back entry, bit 0 is the valid flag and bits FRM_W:1 are the frame number. When bit 0 is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0, and nothing is cached, so a repeated access reads memory again.
- R7: A refill goes into the lowest-numbered empty buffer slot. When no slot is empty, it goes into the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such eviction.
- R8: A cycle with `flush` high empties every buffer slot at the next edge, and a request accepted in that same cycle is treated as a miss.
- R9: A `flush` seen at any point while a miss is pending, up to and including the cycle in which the reply arrives, cancels that miss's refill. The response itself is still delivered.
- R10: Only one translation is outstanding. `req_ready` is low from the acceptance of a miss until its response cycle. `mem_rd_req` stays high with a stable address until `mem_rd_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the table base register |
| cfg_base | input | PA_W | Physical address of table entry 0 |
| flush | input | 1 | Empty the translation buffer |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Page entry was marked not valid |
| mem_rd_req | output | 1 | Table-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table-entry data returned |
| mem_rsp_data | input | FRM_W+1 | Low bits of the entry: frame and valid flag |

## Verification
The hardest situation to reach is a flush that lands while a miss waits on memory, because it needs a miss with a slow reply and a flush in a narrow window. The bench gets there with a directed case that stretches the memory reply delay and raises flush two cycles after acceptance. It then repeats the same page and expects a fresh memory read. Round-robin eviction also needs more pages than buffer slots, so the bench widens the virtual address to eight pages and walks them in a fixed order before random traffic mixes flushes, base changes and invalid entries.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W       = 8,
  parameter int PA_W       = 10,
  parameter int PAGE_BYTES = 64,
  parameter int ENTRIES    = 4,
  parameter int PTE_BYTES  = 2,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int FRM_W  = PA_W - OFF_W,
  localparam int PTE_W  = FRM_W + 1,
  localparam int PTE_SH = $clog2(PTE_BYTES),
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             mem_rd_req,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT} st_t;

  st_t              st_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  rd_addr_q;
  logic [OFF_W-1:0] off_q;
  logic             drop_q;
  logic             rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0]  rsp_paddr_q;

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [FRM_W-1:0]   ent_frm [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  wire [VPN_W-1:0] req_vpn  = req_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] req_off  = req_vaddr[OFF_W-1:0];
  wire             req_fire = req_valid && req_ready;
  wire             pte_ok   = mem_rsp_data[0];
  wire [FRM_W-1:0] pte_frm  = mem_rsp_data[FRM_W:1];

  assign req_ready   = (st_q == S_IDLE);
  assign mem_rd_req  = (st_q == S_RD);
  assign mem_rd_addr = rd_addr_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_paddr   = rsp_paddr_q;
  assign rsp_fault   = rsp_fault_q;

  logic [ENTRIES-1:0] hit_vec;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_vpn[g] == req_vpn) && !flush;
  end
  wire any_hit = |hit_vec;

  logic [FRM_W-1:0] hit_frm;
  always_comb begin
    hit_frm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_frm = hit_frm | ent_frm[i];
  end

  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_v[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
  end
  wire [IDX_W-1:0] victim = have_free ? free_idx : rr_q;

  wire refill = (st_q == S_WAIT) && mem_rsp_valid && pte_ok && !drop_q && !flush;

  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (cfg_we) base_q <= cfg_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      rd_addr_q   <= '0;
      off_q       <= '0;
      vpn_q       <= '0;
      drop_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_fire) begin
          if (any_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= 1'b0;
            rsp_paddr_q <= {hit_frm, req_off};
          end else begin
            st_q      <= S_RD;
            off_q     <= req_off;
            vpn_q     <= req_vpn;
            drop_q    <= 1'b0;
            rd_addr_q <= base_q + (PA_W'(req_vpn) << PTE_SH);
          end
        end
        S_RD: begin
          if (flush) drop_q <= 1'b1;
          if (mem_rd_ready) st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (flush) drop_q <= 1'b1;
          if (mem_rsp_valid) begin
            st_q        <= S_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= !pte_ok;
            rsp_paddr_q <= pte_ok ? {pte_frm, off_q} : '0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      ent_v <= '0;
    end else if (refill) begin
      ent_v[victim] <= 1'b1;
      if (!have_free)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (refill) begin
      ent_vpn[victim] <= vpn_q;
      ent_frm[victim] <= pte_frm;
    end
  end

  p_hit_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_hit_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && any_hit |=> rsp_valid && !rsp_fault);

  p_miss_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) && mem_rsp_valid |=> rsp_valid && req_ready);

  p_fault_nopa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ent_v == '0);

  p_single_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ready |=> mem_rd_req && $stable(mem_rd_addr));

endmodule

// File: tb/tb_page_xlate.sv
`timescale 1ns/1ps
module tb_page_xlate;
  localparam int VA_W = 9, PA_W = 10, PAGE_BYTES = 64, ENTRIES = 4, PTE_BYTES = 2;
  localparam int OFF_W = 6, FRM_W = 4, NPG = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, flush = 1'b0, req_valid = 1'b0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, mem_rd_req;
  logic [PA_W-1:0] rsp_paddr, mem_rd_addr;
  logic mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [FRM_W:0] mem_rsp_data = '0;

  page_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PAGE_BYTES),
               .ENTRIES(ENTRIES), .PTE_BYTES(PTE_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mv [ENTRIES];
  int mvpn [ENTRIES];
  int mfrm [ENTRIES];
  int mrr = 0;
  bit pt_v [NPG];
  int pt_f [NPG];
  int base = 0;
  int acc_dly = 0, rsp_dly = 0, reads = 0, seen_addr = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(int vpn);
    for (int i = 0; i < ENTRIES; i++) if (mv[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void model_fill(int vpn, int frm);
    int slot = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!mv[i]) slot = i;
    if (slot < 0) begin
      slot = mrr;
      mrr = (mrr + 1) % ENTRIES;
    end
    mv[slot] = 1; mvpn[slot] = vpn; mfrm[slot] = frm;
  endfunction

  function automatic void model_flush();
    for (int i = 0; i < ENTRIES; i++) mv[i] = 0;
  endfunction

  function automatic logic [FRM_W:0] pte_at(int addr);
    int idx = ((addr - base) >>> 1) & (NPG - 1);
    return {FRM_W'(pt_f[idx]), pt_v[idx]};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        repeat (acc_dly) @(negedge clk);
        seen_addr = int'(mem_rd_addr);
        reads++;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        mem_rsp_data = pte_at(seen_addr);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic set_base(int b);
    cfg_base = PA_W'(b); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    base = b;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
  endtask

  task automatic new_table(int pct_bad);
    for (int i = 0; i < NPG; i++) begin
      pt_v[i] = (($urandom % 100) >= pct_bad);
      pt_f[i] = $urandom % 16;
    end
  endtask

  task automatic xl(int va, bit fl, bit flush_mid);
    int vpn = (va >> OFF_W) & (NPG - 1);
    int off = va & (PAGE_BYTES - 1);
    int idx, r0, n, expa;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    if (fl) model_flush();
    idx = find(vpn);
    r0 = reads;
    acc_dly = flush_mid ? 1 : int'($urandom % 3);
    rsp_dly = flush_mid ? 5 : int'($urandom % 3);
    req_valid = 1'b1; req_vaddr = VA_W'(va); flush = fl;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    if (idx >= 0) begin
      expa = (mfrm[idx] << OFF_W) | off;
      chk(rsp_valid == 1'b1, "R4 hit answers next cycle", rsp_valid, 1);
      chk(reads == r0, "R4 hit makes no memory read", reads - r0, 0);
      chk(!rsp_fault && rsp_paddr == PA_W'(expa), "R2 hit frame and offset", rsp_paddr, expa);
    end else begin
      chk(req_ready == 1'b0, "R10 ready low while miss pending", req_ready, 0);
      n = 0;
      while (n < 60) begin
        if (rsp_valid) break;
        flush = flush_mid && (n == 1);
        @(negedge clk);
        n++;
      end
      flush = 1'b0;
      if (flush_mid) model_flush();
      chk(rsp_valid == 1'b1, "R5 miss response arrives", rsp_valid, 1);
      chk(reads == r0 + 1, "R5 one memory read per miss", reads - r0, 1);
      chk(seen_addr == ((base + vpn * PTE_BYTES) & 1023), "R3 entry address", seen_addr,
          (base + vpn * PTE_BYTES) & 1023);
      chk(req_ready == 1'b1, "R10 ready back in response cycle", req_ready, 1);
      if (pt_v[vpn]) begin
        expa = (pt_f[vpn] << OFF_W) | off;
        chk(!rsp_fault && rsp_paddr == PA_W'(expa), "R2 miss frame and offset", rsp_paddr, expa);
        if (!flush_mid) model_fill(vpn, pt_f[vpn]);
      end else begin
        chk(rsp_fault && rsp_paddr == '0, "R6 invalid entry faults", {rsp_fault, rsp_paddr}, 1 << PA_W);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(mem_rd_req == 1'b0, "R1 no read after reset", mem_rd_req, 0);

    set_base(10'h100);
    for (int i = 0; i < NPG; i++) begin pt_v[i] = 1; pt_f[i] = (i * 3 + 1) & 15; end
    // R7 fill order then round-robin eviction
    for (int p = 0; p < 4; p++) xl((p << OFF_W) | 5, 0, 0);
    xl((4 << OFF_W) | 63, 0, 0);
    xl((1 << OFF_W) | 0, 0, 0);
    xl((0 << OFF_W) | 9, 0, 0);
    xl((1 << OFF_W) | 7, 0, 0);
    xl((4 << OFF_W) | 1, 0, 0);
    // R6 invalid entry is never cached
    pt_v[6] = 0;
    xl((6 << OFF_W) | 2, 0, 0);
    xl((6 << OFF_W) | 3, 0, 0);
    // R8 flush alone, then flush together with a request
    do_flush();
    xl((3 << OFF_W) | 4, 0, 0);
    xl((3 << OFF_W) | 4, 1, 0);
    xl((3 << OFF_W) | 8, 0, 0);
    // R9 flush while miss pending drops refill
    xl((5 << OFF_W) | 11, 0, 1);
    xl((5 << OFF_W) | 12, 0, 0);
    // R3 new base with address wrap
    set_base(10'h3FA);
    do_flush();
    xl((7 << OFF_W) | 1, 0, 0);
    xl((2 << OFF_W) | 1, 0, 0);

    for (int k = 0; k < 400; k++) begin
      if ($urandom % 40 == 0) begin
        set_base(int'($urandom % 1024) & ~1);
        new_table(25);
        do_flush();
      end
      xl(int'($urandom % 512), ($urandom % 12) == 0, ($urandom % 30) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule